// File: doc/BRIEF.md
# Indexed Display Register Port

This block is the byte-wide register front end of a legacy-style display controller. The host sees a few byte offsets on a simple synchronous bus. Three of those offsets are index ports, each paired with a data port. A write to an index port picks one register inside a bank: sequencer, CRT controller or graphics. A later read or write at the paired data port then reaches that register. Every bank register drives a flat output bus that feeds the timing and pixel-format logic further down the chip.

The palette mask port has a second, hidden register behind it that holds the colour mode. The host reads the mask port four times in a row. The next write to that port then goes to the hidden colour-mode register and leaves the mask alone. The block also decodes the pixel-depth field of sequencer register 7 into a bits-per-pixel value for the pixel pipeline.

Top module: `disp_regport`

## Requirements
- R1: After reset, every bank register, every index register, the mask register and the colour-mode register is 0x00, and so are all outputs and every read.
- R2: A write to an index port (offset 0x04 sequencer, 0x14 CRT controller, 0x0E graphics) stores the byte, and a read of that same offset returns it.
- R3: A write to a data port (0x05 sequencer, 0x15 CRT controller, 0x0F graphics) updates the register chosen by that bank's index, and a read returns it. The same index number in different banks names different registers.
- R4: Indices at or above the bank size (8 sequencer, 32 CRT controller, 9 graphics) read as 0x00, and writes to them change no register.
- R5: Outside the unlock sequence, a write to offset 0x06 sets the palette mask register, and a read of 0x06 returns it.
- R6: After four reads in a row of offset 0x06, the next write to 0x06 loads the colour-mode register and leaves the mask unchanged.
- R7: Any write, or any read of an offset other than 0x06, clears the read count. A write to 0x06 after fewer than four counted reads goes to the mask.
- R8: The write that loads the colour-mode register clears the count, so the write after it goes to the mask. Reads beyond four keep the port unlocked, and idle cycles leave the count as it was.
- R9: `pix_bpp` decodes bits 4:0 of sequencer register 7: 0x11 gives 8, 0x17 gives 16, 0x15 gives 24, 0x19 gives 32, and any other value gives 0. Bits 7:5 are stored and read back but do not affect the decode.
- R10: Offsets with no register read as 0x00, and writes to them change nothing. `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| seq_regs | output | 8*SEQ_N | Sequencer bank contents, register i at bits 8i+7:8i |
| crt_regs | output | 8*CRT_N | CRT controller bank contents |
| gfx_regs | output | 8*GFX_N | Graphics bank contents |
| dac_mask | output | 8 | Palette mask register |
| color_mode | output | 8 | Hidden colour-mode register |
| pix_bpp | output | 6 | Decoded bits per pixel, 0 if the encoding is unknown |

## Verification
The bench targets the edges of the unlock sequence:
- Three reads instead of four. A design that counts wrong sends this write to the colour-mode register.
- Four reads broken up by a read of another port. A design that forgets to clear the count lets a stale count open the hidden path.
- Reads beyond four, and idle cycles in the middle of the reads.
- The write that comes right after the unlock has been used. A design that fails to clear the count afterwards keeps writing the colour mode.

Out-of-range indices in each bank are also exercised, because a design that wraps the index would overwrite a real register. Bank crosstalk at a shared index number is checked. Depth encodings are checked with the upper bits set, which a sloppy decode would misread.

// File: rtl/disp_regport.sv
module disp_regport #(
  parameter int ADDR_W       = 5,
  parameter int SEQ_N        = 8,
  parameter int CRT_N        = 32,
  parameter int GFX_N        = 9,
  parameter int UNLOCK_READS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic [SEQ_N*8-1:0]  seq_regs,
  output logic [CRT_N*8-1:0]  crt_regs,
  output logic [GFX_N*8-1:0]  gfx_regs,
  output logic [7:0]          dac_mask,
  output logic [7:0]          color_mode,
  output logic [5:0]          pix_bpp
);
  localparam logic [ADDR_W-1:0] A_SEQ_IX = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_SEQ_DT = ADDR_W'(5'h05);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(5'h06);
  localparam logic [ADDR_W-1:0] A_GFX_IX = ADDR_W'(5'h0E);
  localparam logic [ADDR_W-1:0] A_GFX_DT = ADDR_W'(5'h0F);
  localparam logic [ADDR_W-1:0] A_CRT_IX = ADDR_W'(5'h14);
  localparam logic [ADDR_W-1:0] A_CRT_DT = ADDR_W'(5'h15);
  localparam int CNT_W    = $clog2(UNLOCK_READS + 1);
  localparam int DEPTH_IX = 7;

  logic [7:0] seq_idx, crt_idx, gfx_idx;
  logic [7:0] seq_q [SEQ_N];
  logic [7:0] crt_q [CRT_N];
  logic [7:0] gfx_q [GFX_N];
  logic [7:0] mask_q, mode_q;
  logic [CNT_W-1:0] rd_cnt;
  logic [7:0] seq_rd, crt_rd, gfx_rd;

  wire unlocked = (rd_cnt == CNT_W'(UNLOCK_READS));
  wire mask_wr  = bus_wr && bus_addr == A_MASK;
  wire seq_we   = bus_wr && bus_addr == A_SEQ_DT;
  wire crt_we   = bus_wr && bus_addr == A_CRT_DT;
  wire gfx_we   = bus_wr && bus_addr == A_GFX_DT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_idx <= '0;
      crt_idx <= '0;
      gfx_idx <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_SEQ_IX) seq_idx <= bus_wdata;
      if (bus_addr == A_CRT_IX) crt_idx <= bus_wdata;
      if (bus_addr == A_GFX_IX) gfx_idx <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEQ_N; i++) seq_q[i] <= '0;
    end else if (seq_we) begin
      for (int i = 0; i < SEQ_N; i++)
        if (seq_idx == 8'(i)) seq_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CRT_N; i++) crt_q[i] <= '0;
    end else if (crt_we) begin
      for (int i = 0; i < CRT_N; i++)
        if (crt_idx == 8'(i)) crt_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GFX_N; i++) gfx_q[i] <= '0;
    end else if (gfx_we) begin
      for (int i = 0; i < GFX_N; i++)
        if (gfx_idx == 8'(i)) gfx_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
    end else if (mask_wr) begin
      if (unlocked) mode_q <= bus_wdata;
      else          mask_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rd_cnt <= '0;
    else if (bus_wr)              rd_cnt <= '0;
    else if (bus_rd) begin
      if (bus_addr != A_MASK)     rd_cnt <= '0;
      else if (!unlocked)         rd_cnt <= rd_cnt + 1'b1;
    end
  end

  always_comb begin
    seq_rd = '0;
    crt_rd = '0;
    gfx_rd = '0;
    for (int i = 0; i < SEQ_N; i++) if (seq_idx == 8'(i)) seq_rd = seq_q[i];
    for (int i = 0; i < CRT_N; i++) if (crt_idx == 8'(i)) crt_rd = crt_q[i];
    for (int i = 0; i < GFX_N; i++) if (gfx_idx == 8'(i)) gfx_rd = gfx_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && !bus_wr) begin
      case (bus_addr)
        A_SEQ_IX: bus_rdata = seq_idx;
        A_SEQ_DT: bus_rdata = seq_rd;
        A_MASK:   bus_rdata = mask_q;
        A_GFX_IX: bus_rdata = gfx_idx;
        A_GFX_DT: bus_rdata = gfx_rd;
        A_CRT_IX: bus_rdata = crt_idx;
        A_CRT_DT: bus_rdata = crt_rd;
        default:  bus_rdata = '0;
      endcase
    end
  end

  always_comb begin
    case (seq_q[DEPTH_IX][4:0])
      5'h11:   pix_bpp = 6'd8;
      5'h17:   pix_bpp = 6'd16;
      5'h15:   pix_bpp = 6'd24;
      5'h19:   pix_bpp = 6'd32;
      default: pix_bpp = 6'd0;
    endcase
  end

  for (genvar g = 0; g < SEQ_N; g++) begin : g_seq_out
    assign seq_regs[g*8 +: 8] = seq_q[g];
  end
  for (genvar g = 0; g < CRT_N; g++) begin : g_crt_out
    assign crt_regs[g*8 +: 8] = crt_q[g];
  end
  for (genvar g = 0; g < GFX_N; g++) begin : g_gfx_out
    assign gfx_regs[g*8 +: 8] = gfx_q[g];
  end

  assign dac_mask   = mask_q;
  assign color_mode = mode_q;
endmodule

module disp_regport_chk #(
  parameter int ADDR_W       = 5,
  parameter int SEQ_N        = 8,
  parameter int CRT_N        = 32,
  parameter int GFX_N        = 9,
  parameter int UNLOCK_READS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [7:0]         bus_wdata,
  input logic [7:0]         bus_rdata,
  input logic [SEQ_N*8-1:0] seq_regs,
  input logic [CRT_N*8-1:0] crt_regs,
  input logic [GFX_N*8-1:0] gfx_regs,
  input logic [7:0]         dac_mask,
  input logic [7:0]         color_mode,
  input logic [5:0]         pix_bpp,
  input logic [7:0]         seq_idx,
  input logic [7:0]         crt_idx,
  input logic [7:0]         gfx_idx
);
  localparam logic [ADDR_W-1:0] A_SEQ_DT = ADDR_W'(5'h05);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(5'h06);
  localparam logic [ADDR_W-1:0] A_GFX_DT = ADDR_W'(5'h0F);
  localparam logic [ADDR_W-1:0] A_CRT_DT = ADDR_W'(5'h15);

  int chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  chk_cnt <= 0;
    else if (bus_wr)                             chk_cnt <= 0;
    else if (bus_rd && bus_addr != A_MASK)       chk_cnt <= 0;
    else if (bus_rd && chk_cnt < UNLOCK_READS)   chk_cnt <= chk_cnt + 1;
  end

  p_mode_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK && chk_cnt == UNLOCK_READS)
      |=> (color_mode == $past(bus_wdata)) && $stable(dac_mask));

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK && chk_cnt != UNLOCK_READS)
      |=> (dac_mask == $past(bus_wdata)) && $stable(color_mode));

  p_seq_unimpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SEQ_DT && int'(seq_idx) >= SEQ_N) |=> $stable(seq_regs));

  p_crt_unimpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CRT_DT && int'(crt_idx) >= CRT_N) |=> $stable(crt_regs));

  p_gfx_unimpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_GFX_DT && int'(gfx_idx) >= GFX_N) |=> $stable(gfx_regs));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(seq_regs) && $stable(crt_regs) && $stable(gfx_regs)
                && $stable(dac_mask) && $stable(color_mode));

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);

  p_bpp_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_bpp == 6'd0 || pix_bpp == 6'd8 || pix_bpp == 6'd16
    || pix_bpp == 6'd24 || pix_bpp == 6'd32);
endmodule

bind disp_regport disp_regport_chk #(
  .ADDR_W(ADDR_W), .SEQ_N(SEQ_N), .CRT_N(CRT_N), .GFX_N(GFX_N),
  .UNLOCK_READS(UNLOCK_READS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .seq_regs(seq_regs), .crt_regs(crt_regs), .gfx_regs(gfx_regs),
  .dac_mask(dac_mask), .color_mode(color_mode), .pix_bpp(pix_bpp),
  .seq_idx(seq_idx), .crt_idx(crt_idx), .gfx_idx(gfx_idx)
);

// File: tb/disp_regport_test.sv
module disp_regport_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5, SEQ_N = 8, CRT_N = 32, GFX_N = 9;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [SEQ_N*8-1:0] seq_regs;
  logic [CRT_N*8-1:0] crt_regs;
  logic [GFX_N*8-1:0] gfx_regs;
  logic [7:0] dac_mask, color_mode;
  logic [5:0] pix_bpp;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [7:0] m_sidx, m_cidx, m_gidx, m_mask, m_mode;
  logic [7:0] m_seq [256];
  logic [7:0] m_crt [256];
  logic [7:0] m_gfx [256];
  int m_cnt;

  disp_regport uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_regs(seq_regs), .crt_regs(crt_regs), .gfx_regs(gfx_regs),
    .dac_mask(dac_mask), .color_mode(color_mode), .pix_bpp(pix_bpp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_bpp(input logic [7:0] v);
    case (v[4:0])
      5'h11: return 8;
      5'h17: return 16;
      5'h15: return 24;
      5'h19: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    case (a)
      5'h04: return m_sidx;
      5'h05: return (m_sidx < SEQ_N) ? m_seq[m_sidx] : 8'h00;
      5'h06: return m_mask;
      5'h0E: return m_gidx;
      5'h0F: return (m_gidx < GFX_N) ? m_gfx[m_gidx] : 8'h00;
      5'h14: return m_cidx;
      5'h15: return (m_cidx < CRT_N) ? m_crt[m_cidx] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_sidx = 0; m_cidx = 0; m_gidx = 0; m_mask = 0; m_mode = 0; m_cnt = 0;
    for (int i = 0; i < 256; i++) begin m_seq[i] = 0; m_crt[i] = 0; m_gfx[i] = 0; end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    #1 bus_wr = 0;
    case (a)
      5'h04: m_sidx = d;
      5'h05: if (m_sidx < SEQ_N) m_seq[m_sidx] = d;
      5'h06: if (m_cnt == 4) m_mode = d; else m_mask = d;
      5'h0E: m_gidx = d;
      5'h0F: if (m_gidx < GFX_N) m_gfx[m_gidx] = d;
      5'h14: m_cidx = d;
      5'h15: if (m_cidx < CRT_N) m_crt[m_cidx] = d;
      default: ;
    endcase
    m_cnt = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 0;
    if (a == 5'h06) begin if (m_cnt < 4) m_cnt++; end
    else m_cnt = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a);
    logic [7:0] e, d;
    e = exp_read(a);
    rd(a, d);
    chk(tag, d, e);
  endtask

  task automatic out_chk(input string tag);
    chk({tag, " mask"}, dac_mask, m_mask);
    chk({tag, " mode"}, color_mode, m_mode);
    chk({tag, " bpp"}, pix_bpp, exp_bpp(m_seq[7]));
  endtask

  task automatic banks_chk(input string tag);
    for (int i = 0; i < SEQ_N; i++) chk({tag, " seq"}, seq_regs[i*8 +: 8], m_seq[i]);
    for (int i = 0; i < CRT_N; i++) chk({tag, " crt"}, crt_regs[i*8 +: 8], m_crt[i]);
    for (int i = 0; i < GFX_N; i++) chk({tag, " gfx"}, gfx_regs[i*8 +: 8], m_gfx[i]);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd5417));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    out_chk("R1");
    banks_chk("R1");
    for (int a = 0; a < 32; a++) rd_chk("R1", 5'(a));

    // R2 index readback
    wr(5'h04, 8'h07); rd_chk("R2", 5'h04);
    wr(5'h14, 8'h1B); rd_chk("R2", 5'h14);
    wr(5'h0E, 8'h05); rd_chk("R2", 5'h0E);

    // R3 banks are independent at the same index
    wr(5'h04, 8'h03); wr(5'h05, 8'hA1);
    wr(5'h14, 8'h03); wr(5'h15, 8'hB2);
    wr(5'h0E, 8'h03); wr(5'h0F, 8'hC3);
    rd_chk("R3", 5'h05); rd_chk("R3", 5'h15); rd_chk("R3", 5'h0F);
    banks_chk("R3");

    // R4 out-of-range indices
    wr(5'h04, 8'h08); wr(5'h05, 8'h5A); rd_chk("R4", 5'h05);
    wr(5'h14, 8'h20); wr(5'h15, 8'h5A); rd_chk("R4", 5'h15);
    wr(5'h0E, 8'h09); wr(5'h0F, 8'h5A); rd_chk("R4", 5'h0F);
    banks_chk("R4");

    // R5 plain mask access
    wr(5'h06, 8'h3C); out_chk("R5"); rd_chk("R5", 5'h06);

    // R6 unlock after four reads
    repeat (4) rd_chk("R6", 5'h06);
    wr(5'h06, 8'hC1);
    chk("R6 mode", color_mode, 8'hC1); chk("R6 mask kept", dac_mask, 8'h3C);

    // R8 consuming write clears the count
    wr(5'h06, 8'h77); out_chk("R8 after unlock");

    // R7 three reads only
    repeat (3) rd_chk("R7", 5'h06);
    wr(5'h06, 8'h11); out_chk("R7 three reads");

    // R7 interrupted by a read of another port
    repeat (2) rd_chk("R7", 5'h06);
    rd_chk("R7", 5'h04);
    repeat (2) rd_chk("R7", 5'h06);
    wr(5'h06, 8'h22); out_chk("R7 interrupted");

    // R8 idle cycles inside the sequence, and extra reads
    repeat (2) rd_chk("R8", 5'h06);
    repeat (3) @(negedge clk);
    repeat (2) rd_chk("R8", 5'h06);
    wr(5'h06, 8'hC5); out_chk("R8 idle gap");
    repeat (6) rd_chk("R8", 5'h06);
    wr(5'h06, 8'h00); out_chk("R8 extra reads");

    // R9 depth decode with upper bits set
    wr(5'h04, 8'h07);
    wr(5'h05, 8'hF7); out_chk("R9 16"); rd_chk("R9", 5'h05);
    wr(5'h05, 8'hE0 | 8'h11); out_chk("R9 8");
    wr(5'h05, 8'h15); out_chk("R9 24");
    wr(5'h05, 8'hA0 | 8'h19); out_chk("R9 32"); rd_chk("R9", 5'h05);
    wr(5'h05, 8'h12); out_chk("R9 unknown");

    // R10 unmapped offsets
    wr(5'h1F, 8'hFF); wr(5'h00, 8'hEE); wr(5'h07, 8'hDD);
    rd_chk("R10", 5'h1F); rd_chk("R10", 5'h00); rd_chk("R10", 5'h07);
    out_chk("R10"); banks_chk("R10");
    @(negedge clk); chk("R10 idle rdata", bus_rdata, 0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [4:0] a;
      logic [7:0] v;
      r = $urandom % 16;
      case (r)
        0, 1, 2, 3, 4: a = 5'h06;
        5:  a = 5'h04;
        6:  a = 5'h05;
        7:  a = 5'h14;
        8:  a = 5'h15;
        9:  a = 5'h0E;
        10: a = 5'h0F;
        default: a = 5'($urandom % 32);
      endcase
      if (a == 5'h04 || a == 5'h14 || a == 5'h0E) v = 8'($urandom % 40);
      else v = 8'($urandom);
      if ($urandom % 3 == 0) begin
        wr(a, v);
        out_chk("R3 random");
      end else begin
        rd_chk("R3 random", a);
      end
    end
    banks_chk("R3 random");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule